// File: doc/BRIEF.md
# Write-Combining Per-Thread Store Queue

This block sits beside a write-through L1 data cache that four hardware threads share. Each thread owns a single queue entry that holds one full 64-byte line, a per-byte write mask and a command (store, flush or invalidate). The pipeline hands it stores and cache-control commands. A store that lands on the line already waiting in its thread's entry, before that entry has gone to the L2, is merged in place. Any other store that meets a busy entry rolls the thread back and parks it until the entry drains.

The entries that are waiting to go out compete round-robin for one L2 request port. An entry moves from `WAIT_SEND` to `WAIT_RESP` when the L2 accepts it. It is released only when the L2 answers with that thread's id. Holding the entry until the answer means a thread never has two stores in flight, so every core sees one thread's stores in a single order. In parallel with every load's cache lookup, the queue returns the pending bytes of the loading thread's own entry, with a byte mask, so the load path can overlay them. A memory barrier parks its thread while that thread still has anything pending.

Each entry is a three-state machine held in two bits (valid, sent):
- `EMPTY` (00) goes to `WAIT_SEND` when a store or command is allocated.
- `WAIT_SEND` (10) stays put, possibly merging stores, until the L2 accepts it, then goes to `WAIT_RESP`.
- `WAIT_RESP` (11) goes to `EMPTY` on a matching response. It goes straight back to `WAIT_SEND` if a new command from the same thread arrives in the response cycle.

Top module: `wc_store_queue`

## Requirements
- R1: After reset every entry is empty, `l2_req_valid`, `rollback`, `stall_mask` and `wake_mask` are 0.
- R2: A command to an empty entry of thread t is taken at the clock edge, and from the next cycle the L2 request offers tid t with that line, mask and command (command codes: 0 store, 1 flush, 2 invalidate).
- R3: A store (code 0) to the same line while the entry is in `WAIT_SEND` and not being accepted in that cycle is merged: each byte i whose mask bit is set overwrites data bits [8i+7:8i], and the new mask bits are ORed into the entry mask, with no rollback.
- R4: A command to a different line while the thread's entry is pending raises `rollback` combinationally in that cycle, and the thread's `stall_mask` bit is set from the next cycle.
- R5: A store to the same line after the entry has been accepted by the L2 (or in the cycle it is accepted) rolls back and stalls the thread in the same way.
- R6: Flush (code 1) and invalidate (code 2) never merge with a store (code 0), in either order; a mix of the two on one line rolls back.
- R7: While `l2_req_valid` is high and `l2_req_ready` is low, the offered tid, line and command hold until accepted.
- R8: An entry is freed only by an L2 response whose `l2_rsp_tid` names its thread while it is in `WAIT_RESP`; at that edge a stalled thread's `stall_mask` bit clears and its `wake_mask` bit pulses for one cycle.
- R9: With `ld_valid` high, if the loading thread's own entry is pending with a store command to `ld_line`, `ld_fwd_mask` equals the entry mask and `ld_fwd_data` carries the entry bytes under that mask (zero elsewhere); otherwise both are zero.
- R10: A barrier parks its thread (`stall_mask` bit set from the next cycle) only if that thread's entry is pending; with nothing pending it has no effect.
- R11: A command from thread t in the same cycle as t's L2 response is not rolled back; the entry is freed and reallocated with the new command, offered from the next cycle.
- R12: After an acceptance from thread t, the next grant goes to the first waiting thread after t in cyclic order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_valid | input | 1 | Store or cache command issued this cycle |
| st_tid | input | 2 | Issuing thread |
| st_cmd | input | 2 | 0 store, 1 flush, 2 invalidate |
| st_line | input | 26 | Line address (byte address bits 31:6) |
| st_data | input | 512 | Line data, byte i in bits 8i+7:8i |
| st_mask | input | 64 | Byte write mask |
| rollback | output | 1 | Issued command refused; roll the thread back |
| mb_valid | input | 1 | Memory barrier issued this cycle |
| mb_tid | input | 2 | Barrier thread |
| ld_valid | input | 1 | Load lookup this cycle |
| ld_tid | input | 2 | Loading thread |
| ld_line | input | 26 | Load line address |
| ld_fwd_data | output | 512 | Forwarded bytes, zero outside the mask |
| ld_fwd_mask | output | 64 | Bytes supplied by the queue |
| l2_req_valid | output | 1 | Request offered to the L2 |
| l2_req_ready | input | 1 | L2 accepts the offered request |
| l2_req_tid | output | 2 | Thread of the offered request |
| l2_req_cmd | output | 2 | Command of the offered request |
| l2_req_line | output | 26 | Line of the offered request |
| l2_req_data | output | 512 | Data of the offered request |
| l2_req_mask | output | 64 | Byte mask of the offered request |
| l2_rsp_valid | input | 1 | L2 completion |
| l2_rsp_tid | input | 2 | Thread whose request completed |
| stall_mask | output | 4 | Threads parked on the queue |
| wake_mask | output | 4 | One-cycle wake pulse per thread |

## Verification
The case that matters most is an L2 completion for a thread landing in the same cycle as a new command from that same thread. In that cycle the release of the old entry and the allocation of the new one compete for one register set. The bench accepts a store, then drives the response and a store to another line together. The design must not roll back in that cycle, must offer the new line on the next cycle, and must leave the thread unparked. A second collision, a merge attempt in the very cycle the L2 accepts the entry, is covered by the rule that such a store rolls back rather than merging.

// File: rtl/sq_pkg.sv
package sq_pkg;

    // Entry state, encoded directly as {valid, sent}
    typedef enum logic [1:0] {
        SQ_EMPTY     = 2'b00,
        SQ_WAIT_SEND = 2'b10,
        SQ_WAIT_RESP = 2'b11
    } sq_state_e;

    // Command codes carried on st_cmd / l2_req_cmd
    typedef enum logic [1:0] {
        CMD_STORE = 2'd0,
        CMD_FLUSH = 2'd1,
        CMD_INVAL = 2'd2
    } sq_cmd_e;

endpackage

// File: rtl/sq_entry.sv
module sq_entry
    import sq_pkg::*;
#(
    parameter int LINE_BYTES = 64,
    parameter int LA_W       = 26
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    st_hit,
    input  logic [1:0]              st_cmd,
    input  logic [LA_W-1:0]         st_line,
    input  logic [LINE_BYTES*8-1:0] st_data,
    input  logic [LINE_BYTES-1:0]   st_mask,
    input  logic                    accept,
    input  logic                    rsp,
    input  logic                    mb_hit,
    output logic                    pend_send,
    output logic                    pending,
    output logic [1:0]              cmd,
    output logic [LA_W-1:0]         line,
    output logic [LINE_BYTES*8-1:0] data,
    output logic [LINE_BYTES-1:0]   mask,
    output logic                    rollback,
    output logic                    stall,
    output logic                    wake
);

    logic                    valid_q, sent_q;
    sq_state_e               state, state_nx;
    logic [1:0]              cmd_q;
    logic [LA_W-1:0]         line_q;
    logic [LINE_BYTES*8-1:0] data_q;
    logic [LINE_BYTES-1:0]   mask_q;
    logic                    stall_q, wake_q;
    logic                    rsp_free, can_alloc, can_merge;
    logic                    do_alloc, do_merge, mb_wait;

    assign state = sq_state_e'({valid_q, sent_q});

    // Decisions taken for the command presented this cycle
    always_comb begin
        rsp_free  = rsp && (state == SQ_WAIT_RESP);
        can_alloc = (state == SQ_EMPTY) || rsp_free;
        can_merge = (state == SQ_WAIT_SEND) && !accept &&
                    (st_cmd == CMD_STORE) && (cmd_q == CMD_STORE) &&
                    (st_line == line_q);
        do_alloc  = st_hit && can_alloc;
        do_merge  = st_hit && can_merge;
        rollback  = st_hit && !can_alloc && !can_merge;
        mb_wait   = mb_hit && (state != SQ_EMPTY) && !rsp_free;
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            SQ_EMPTY: begin
                if (do_alloc) state_nx = SQ_WAIT_SEND;
            end
            SQ_WAIT_SEND: begin
                if (accept) state_nx = SQ_WAIT_RESP;
            end
            SQ_WAIT_RESP: begin
                if (do_alloc)      state_nx = SQ_WAIT_SEND;
                else if (rsp_free) state_nx = SQ_EMPTY;
            end
            default: state_nx = SQ_EMPTY;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            sent_q  <= 1'b0;
        end else begin
            {valid_q, sent_q} <= state_nx;
        end
    end

    // Entry header and mask
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q  <= CMD_STORE;
            line_q <= '0;
            mask_q <= '0;
        end else if (do_alloc) begin
            cmd_q  <= st_cmd;
            line_q <= st_line;
            mask_q <= st_mask;
        end else if (do_merge) begin
            mask_q <= mask_q | st_mask;
        end
    end

    // Data lanes: full load on allocation, masked overwrite on merge
    always_ff @(posedge clk) begin
        for (int b = 0; b < LINE_BYTES; b++) begin
            if (do_alloc || (do_merge && st_mask[b]))
                data_q[b*8 +: 8] <= st_data[b*8 +: 8];
        end
    end

    // Park / wake bookkeeping for the owning thread
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stall_q <= 1'b0;
            wake_q  <= 1'b0;
        end else begin
            wake_q <= stall_q && rsp_free;
            if (rsp_free)                stall_q <= 1'b0;
            else if (rollback || mb_wait) stall_q <= 1'b1;
        end
    end

    // Outputs
    always_comb begin
        pend_send = (state == SQ_WAIT_SEND);
        pending   = valid_q;
        cmd       = cmd_q;
        line      = line_q;
        data      = data_q;
        mask      = mask_q;
        stall     = stall_q;
        wake      = wake_q;
    end

endmodule

// File: rtl/sq_rr_arb.sv
module sq_rr_arb #(
    parameter int NT    = 4,
    parameter int TID_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NT-1:0]    req,
    input  logic             ready,
    output logic             gnt_valid,
    output logic [TID_W-1:0] gnt_id
);

    logic             hold_q;
    logic [TID_W-1:0] held_q, ptr_q;
    logic             pick_valid;
    logic [TID_W-1:0] pick_id, idx;

    // Rotating-priority search, overridden while a refused offer is held
    always_comb begin
        pick_valid = 1'b0;
        pick_id    = '0;
        idx        = '0;
        for (int k = 0; k < NT; k++) begin
            idx = TID_W'((int'(ptr_q) + k) % NT);
            if (!pick_valid && req[idx]) begin
                pick_valid = 1'b1;
                pick_id    = idx;
            end
        end
        if (hold_q) begin
            gnt_valid = 1'b1;
            gnt_id    = held_q;
        end else begin
            gnt_valid = pick_valid;
            gnt_id    = pick_id;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= 1'b0;
            held_q <= '0;
            ptr_q  <= '0;
        end else if (gnt_valid) begin
            if (ready) begin
                hold_q <= 1'b0;
                ptr_q  <= (gnt_id == TID_W'(NT-1)) ? '0 : gnt_id + 1'b1;
            end else begin
                hold_q <= 1'b1;
                held_q <= gnt_id;
            end
        end
    end

endmodule

// File: rtl/sq_fwd.sv
module sq_fwd
    import sq_pkg::*;
#(
    parameter int NT         = 4,
    parameter int TID_W      = 2,
    parameter int LINE_BYTES = 64,
    parameter int LA_W       = 26
) (
    input  logic                               ld_valid,
    input  logic [TID_W-1:0]                   ld_tid,
    input  logic [LA_W-1:0]                    ld_line,
    input  logic [NT-1:0]                      ent_pending,
    input  logic [NT-1:0][1:0]                 ent_cmd,
    input  logic [NT-1:0][LA_W-1:0]            ent_line,
    input  logic [NT-1:0][LINE_BYTES*8-1:0]    ent_data,
    input  logic [NT-1:0][LINE_BYTES-1:0]      ent_mask,
    output logic [LINE_BYTES*8-1:0]            fwd_data,
    output logic [LINE_BYTES-1:0]              fwd_mask
);

    logic hit;

    always_comb begin
        hit = ld_valid && ent_pending[ld_tid] &&
              (ent_cmd[ld_tid] == CMD_STORE) &&
              (ent_line[ld_tid] == ld_line);
        fwd_mask = hit ? ent_mask[ld_tid] : '0;
        for (int b = 0; b < LINE_BYTES; b++)
            fwd_data[b*8 +: 8] = fwd_mask[b] ? ent_data[ld_tid][b*8 +: 8] : 8'h00;
    end

endmodule

// File: rtl/wc_store_queue.sv
module wc_store_queue
    import sq_pkg::*;
#(
    parameter int NT         = 4,
    parameter int LINE_BYTES = 64,
    parameter int ADDR_W     = 32,
    localparam int TID_W     = $clog2(NT),
    localparam int LA_W      = ADDR_W - $clog2(LINE_BYTES),
    localparam int LINE_BITS = LINE_BYTES * 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  st_valid,
    input  logic [TID_W-1:0]      st_tid,
    input  logic [1:0]            st_cmd,
    input  logic [LA_W-1:0]       st_line,
    input  logic [LINE_BITS-1:0]  st_data,
    input  logic [LINE_BYTES-1:0] st_mask,
    output logic                  rollback,
    input  logic                  mb_valid,
    input  logic [TID_W-1:0]      mb_tid,
    input  logic                  ld_valid,
    input  logic [TID_W-1:0]      ld_tid,
    input  logic [LA_W-1:0]       ld_line,
    output logic [LINE_BITS-1:0]  ld_fwd_data,
    output logic [LINE_BYTES-1:0] ld_fwd_mask,
    output logic                  l2_req_valid,
    input  logic                  l2_req_ready,
    output logic [TID_W-1:0]      l2_req_tid,
    output logic [1:0]            l2_req_cmd,
    output logic [LA_W-1:0]       l2_req_line,
    output logic [LINE_BITS-1:0]  l2_req_data,
    output logic [LINE_BYTES-1:0] l2_req_mask,
    input  logic                  l2_rsp_valid,
    input  logic [TID_W-1:0]      l2_rsp_tid,
    output logic [NT-1:0]         stall_mask,
    output logic [NT-1:0]         wake_mask
);

    logic [NT-1:0]                 ent_send, ent_pending, ent_rb;
    logic [NT-1:0][1:0]            ent_cmd;
    logic [NT-1:0][LA_W-1:0]       ent_line;
    logic [NT-1:0][LINE_BITS-1:0]  ent_data;
    logic [NT-1:0][LINE_BYTES-1:0] ent_mask;
    logic                          gnt_valid;
    logic [TID_W-1:0]              gnt_id;

    for (genvar i = 0; i < NT; i++) begin : g_ent
        logic st_hit, accept, rsp, mb_hit;
        assign st_hit = st_valid && (st_tid == TID_W'(i));
        assign accept = gnt_valid && l2_req_ready && (gnt_id == TID_W'(i));
        assign rsp    = l2_rsp_valid && (l2_rsp_tid == TID_W'(i));
        assign mb_hit = mb_valid && (mb_tid == TID_W'(i));

        sq_entry #(
            .LINE_BYTES (LINE_BYTES),
            .LA_W       (LA_W)
        ) u_entry (
            .clk       (clk),
            .rst_n     (rst_n),
            .st_hit    (st_hit),
            .st_cmd    (st_cmd),
            .st_line   (st_line),
            .st_data   (st_data),
            .st_mask   (st_mask),
            .accept    (accept),
            .rsp       (rsp),
            .mb_hit    (mb_hit),
            .pend_send (ent_send[i]),
            .pending   (ent_pending[i]),
            .cmd       (ent_cmd[i]),
            .line      (ent_line[i]),
            .data      (ent_data[i]),
            .mask      (ent_mask[i]),
            .rollback  (ent_rb[i]),
            .stall     (stall_mask[i]),
            .wake      (wake_mask[i])
        );
    end

    sq_rr_arb #(
        .NT    (NT),
        .TID_W (TID_W)
    ) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (ent_send),
        .ready     (l2_req_ready),
        .gnt_valid (gnt_valid),
        .gnt_id    (gnt_id)
    );

    sq_fwd #(
        .NT         (NT),
        .TID_W      (TID_W),
        .LINE_BYTES (LINE_BYTES),
        .LA_W       (LA_W)
    ) u_fwd (
        .ld_valid    (ld_valid),
        .ld_tid      (ld_tid),
        .ld_line     (ld_line),
        .ent_pending (ent_pending),
        .ent_cmd     (ent_cmd),
        .ent_line    (ent_line),
        .ent_data    (ent_data),
        .ent_mask    (ent_mask),
        .fwd_data    (ld_fwd_data),
        .fwd_mask    (ld_fwd_mask)
    );

    // L2 request port driven from the granted entry
    always_comb begin
        l2_req_valid = gnt_valid;
        l2_req_tid   = gnt_id;
        l2_req_cmd   = ent_cmd[gnt_id];
        l2_req_line  = ent_line[gnt_id];
        l2_req_data  = ent_data[gnt_id];
        l2_req_mask  = ent_mask[gnt_id];
        rollback     = |ent_rb;
    end

endmodule

// File: rtl/sq_checker.sv
module sq_checker #(
    parameter int NT    = 4,
    parameter int TID_W = 2,
    parameter int LINE_BYTES = 64,
    parameter int LA_W  = 26
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  st_valid,
    input logic [TID_W-1:0]      st_tid,
    input logic                  rollback,
    input logic                  ld_valid,
    input logic [LINE_BYTES-1:0] ld_fwd_mask,
    input logic                  l2_req_valid,
    input logic                  l2_req_ready,
    input logic [TID_W-1:0]      l2_req_tid,
    input logic [1:0]            l2_req_cmd,
    input logic [LA_W-1:0]       l2_req_line,
    input logic                  l2_rsp_valid,
    input logic [TID_W-1:0]      l2_rsp_tid,
    input logic [NT-1:0]         stall_mask,
    input logic [NT-1:0]         wake_mask
);

    p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        l2_req_valid && !l2_req_ready |=>
            l2_req_valid && $stable(l2_req_tid) && $stable(l2_req_line) && $stable(l2_req_cmd));

    p_rollback_parks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rollback |=> stall_mask[$past(st_tid)]);

    p_no_fwd_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_valid |-> (ld_fwd_mask == '0));

    p_fresh_alloc_r11: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid && l2_rsp_valid && (st_tid == l2_rsp_tid) |-> !rollback);

    for (genvar i = 0; i < NT; i++) begin : g_thr
        p_wake_after_park_r8: assert property (@(posedge clk) disable iff (!rst_n)
            wake_mask[i] |-> $past(stall_mask[i]) && !stall_mask[i]);
    end

endmodule

bind wc_store_queue sq_checker #(
    .NT         (NT),
    .TID_W      (TID_W),
    .LINE_BYTES (LINE_BYTES),
    .LA_W       (LA_W)
) u_sq_chk (.*);

// File: tb/tb_wc_store_queue.sv
`timescale 1ns/1ps
module tb_wc_store_queue;

    logic         clk, rst_n;
    logic         st_valid;
    logic [1:0]   st_tid, st_cmd;
    logic [25:0]  st_line;
    logic [511:0] st_data;
    logic [63:0]  st_mask;
    logic         rollback;
    logic         mb_valid;
    logic [1:0]   mb_tid;
    logic         ld_valid;
    logic [1:0]   ld_tid;
    logic [25:0]  ld_line;
    logic [511:0] ld_fwd_data;
    logic [63:0]  ld_fwd_mask;
    logic         l2_req_valid, l2_req_ready;
    logic [1:0]   l2_req_tid, l2_req_cmd;
    logic [25:0]  l2_req_line;
    logic [511:0] l2_req_data;
    logic [63:0]  l2_req_mask;
    logic         l2_rsp_valid;
    logic [1:0]   l2_rsp_tid;
    logic [3:0]   stall_mask, wake_mask;

    int n_run  = 0;
    int n_fail = 0;

    wc_store_queue dut (.*);

    initial clk = 1'b0;
    always #2.5 clk = ~clk;

    task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic issue(input int tid, input logic [1:0] cmd, input logic [25:0] line,
                         input logic [7:0] fill, input logic [63:0] m, input bit exp_rb, input string rq);
        st_valid = 1'b1; st_tid = 2'(tid); st_cmd = cmd; st_line = line;
        st_data = {64{fill}}; st_mask = m;
        #1;
        chk(rollback == exp_rb, rq, 64'(rollback), 64'(exp_rb));
        cyc();
        st_valid = 1'b0;
    endtask

    task automatic drain(input int tid, input string rq);
        l2_req_ready = 1'b1;
        cyc();
        l2_req_ready = 1'b0;
        l2_rsp_valid = 1'b1; l2_rsp_tid = 2'(tid);
        cyc();
        l2_rsp_valid = 1'b0;
        chk(stall_mask[tid] == 1'b0, rq, 64'(stall_mask), 64'(0));
        cyc();
    endtask

    task automatic t_reset();
        chk(l2_req_valid == 1'b0 && rollback == 1'b0, "R1", 64'(l2_req_valid), 64'(0));
        chk(stall_mask == 4'b0 && wake_mask == 4'b0, "R1", 64'({stall_mask, wake_mask}), 64'(0));
    endtask

    task automatic t_merge_and_complete();
        issue(0, 2'd0, 26'h10, 8'h11, 64'h0F, 1'b0, "R2");
        chk(l2_req_valid && l2_req_tid == 2'd0 && l2_req_line == 26'h10, "R2", 64'(l2_req_line), 64'h10);
        chk(l2_req_mask == 64'h0F && l2_req_cmd == 2'd0, "R2", l2_req_mask, 64'h0F);
        issue(0, 2'd0, 26'h10, 8'h22, 64'hF0, 1'b0, "R3");
        chk(l2_req_mask == 64'hFF, "R3", l2_req_mask, 64'hFF);
        chk(l2_req_data[63:0] == 64'h22222222_11111111, "R3", l2_req_data[63:0], 64'h22222222_11111111);
        l2_req_ready = 1'b1; cyc(); l2_req_ready = 1'b0;
        chk(l2_req_valid == 1'b0, "R8", 64'(l2_req_valid), 64'(0));
        issue(0, 2'd0, 26'h10, 8'h33, 64'h01, 1'b1, "R5");
        chk(stall_mask == 4'b0001, "R5", 64'(stall_mask), 64'h1);
        ld_valid = 1'b1; ld_tid = 2'd0; ld_line = 26'h10; #1;
        chk(ld_fwd_mask == 64'hFF, "R9", ld_fwd_mask, 64'hFF);
        chk(ld_fwd_data[63:0] == 64'h22222222_11111111, "R9", ld_fwd_data[63:0], 64'h22222222_11111111);
        ld_valid = 1'b0;
        l2_rsp_valid = 1'b1; l2_rsp_tid = 2'd0; cyc(); l2_rsp_valid = 1'b0;
        chk(stall_mask == 4'b0 && wake_mask == 4'b0001, "R8", 64'({stall_mask, wake_mask}), 64'h01);
        cyc();
        chk(wake_mask == 4'b0, "R8", 64'(wake_mask), 64'(0));
    endtask

    task automatic t_other_line();
        issue(1, 2'd0, 26'h20, 8'h33, 64'h0F, 1'b0, "R4");
        issue(1, 2'd0, 26'h21, 8'h44, 64'h0F, 1'b1, "R4");
        chk(stall_mask == 4'b0010, "R4", 64'(stall_mask), 64'h2);
        ld_valid = 1'b1; ld_tid = 2'd1; ld_line = 26'h20; #1;
        chk(ld_fwd_mask == 64'h0F && ld_fwd_data[63:0] == 64'h33333333, "R9", ld_fwd_data[63:0], 64'h33333333);
        ld_tid = 2'd2; #1;
        chk(ld_fwd_mask == 64'h0, "R9", ld_fwd_mask, 64'h0);
        ld_tid = 2'd1; ld_line = 26'h21; #1;
        chk(ld_fwd_mask == 64'h0, "R9", ld_fwd_mask, 64'h0);
        ld_valid = 1'b0;
        drain(1, "R8");
    endtask

    task automatic t_cmd_no_merge();
        issue(2, 2'd1, 26'h30, 8'h44, 64'hFF, 1'b0, "R6");
        chk(l2_req_cmd == 2'd1 && l2_req_tid == 2'd2, "R6", 64'(l2_req_cmd), 64'h1);
        issue(2, 2'd0, 26'h30, 8'h55, 64'h01, 1'b1, "R6");
        ld_valid = 1'b1; ld_tid = 2'd2; ld_line = 26'h30; #1;
        chk(ld_fwd_mask == 64'h0, "R9", ld_fwd_mask, 64'h0);
        ld_valid = 1'b0;
        drain(2, "R6");
        issue(2, 2'd0, 26'h30, 8'h55, 64'h01, 1'b0, "R6");
        issue(2, 2'd2, 26'h30, 8'h00, 64'h00, 1'b1, "R6");
        chk(l2_req_cmd == 2'd0 && l2_req_mask == 64'h01, "R6", l2_req_mask, 64'h01);
        drain(2, "R6");
    endtask

    task automatic t_barrier();
        mb_valid = 1'b1; mb_tid = 2'd3; cyc(); mb_valid = 1'b0;
        chk(stall_mask == 4'b0, "R10", 64'(stall_mask), 64'(0));
        issue(3, 2'd0, 26'h40, 8'h66, 64'h01, 1'b0, "R10");
        mb_valid = 1'b1; mb_tid = 2'd3; cyc(); mb_valid = 1'b0;
        chk(stall_mask == 4'b1000, "R10", 64'(stall_mask), 64'h8);
        l2_req_ready = 1'b1; cyc(); l2_req_ready = 1'b0;
        l2_rsp_valid = 1'b1; l2_rsp_tid = 2'd3; cyc(); l2_rsp_valid = 1'b0;
        chk(stall_mask == 4'b0 && wake_mask == 4'b1000, "R10", 64'(wake_mask), 64'h8);
        cyc();
    endtask

    task automatic t_rsp_and_store();
        issue(0, 2'd0, 26'h50, 8'h66, 64'h01, 1'b0, "R11");
        l2_req_ready = 1'b1; cyc(); l2_req_ready = 1'b0;
        l2_rsp_valid = 1'b1; l2_rsp_tid = 2'd0;
        issue(0, 2'd0, 26'h51, 8'h77, 64'h03, 1'b0, "R11");
        l2_rsp_valid = 1'b0;
        chk(l2_req_valid && l2_req_line == 26'h51 && l2_req_mask == 64'h03, "R11", 64'(l2_req_line), 64'h51);
        chk(stall_mask == 4'b0, "R11", 64'(stall_mask), 64'(0));
        drain(0, "R11");
    endtask

    task automatic t_round_robin();
        for (int t = 0; t < 4; t++)
            issue(t, 2'd0, 26'(26'h60 + t), 8'(t), 64'h01, 1'b0, "R12");
        chk(l2_req_valid && l2_req_tid == 2'd0 && l2_req_line == 26'h60, "R7", 64'(l2_req_tid), 64'(0));
        cyc();
        chk(l2_req_tid == 2'd0 && l2_req_line == 26'h60, "R7", 64'(l2_req_line), 64'h60);
        l2_req_ready = 1'b1;
        for (int k = 0; k < 4; k++) begin
            chk(l2_req_valid && l2_req_tid == 2'(k), "R12", 64'(l2_req_tid), 64'(k));
            cyc();
        end
        l2_req_ready = 1'b0;
        chk(l2_req_valid == 1'b0, "R12", 64'(l2_req_valid), 64'(0));
        for (int k = 0; k < 4; k++) begin
            l2_rsp_valid = 1'b1; l2_rsp_tid = 2'(k); cyc();
        end
        l2_rsp_valid = 1'b0;
        issue(1, 2'd0, 26'h70, 8'h01, 64'h01, 1'b0, "R8");
        drain(1, "R8");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 20000, 0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        st_valid = 1'b0; st_tid = '0; st_cmd = '0; st_line = '0; st_data = '0; st_mask = '0;
        mb_valid = 1'b0; mb_tid = '0;
        ld_valid = 1'b0; ld_tid = '0; ld_line = '0;
        l2_req_ready = 1'b0; l2_rsp_valid = 1'b0; l2_rsp_tid = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        cyc();
        t_reset();
        t_merge_and_complete();
        t_other_line();
        t_cmd_no_merge();
        t_barrier();
        t_rsp_and_store();
        t_round_robin();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule